// File: doc/BRIEF.md
# I2C Transfer-Stop Flag and Clock Hold

This block runs next to an I2C bit/byte engine and owns three pieces of per-byte state. The first is the transfer-stop flag: it tells software that a byte, including its acknowledge bit, has finished under a condition that needs attention. The second is the arbitration-lost flag. The third is the request that pulls SCL low so the bus pauses between bytes. The engine reports what happens on the bus through single-cycle strobes: byte-with-ACK finished, start seen, stop seen, arbitration lost, and a start attempted by another device while the bus was busy. It also supplies level status: master, addressed slave, general call, bus busy, and the sampled SDA and SCL lines.

Software reaches the block through a one-cycle write strobe with a 4-bit data word. Bit 0 is the transfer-stop flag, bit 1 is the arbitration-lost flag, bit 2 is the interrupt enable and bit 3 is the master-start request. The two flag bits can only be cleared by software, by writing 0. Writing 1 to either of them does nothing. The transfer-stop flag holds SCL low until it is cleared. A start or stop condition seen while the device is master clears it on its own. A master-start request made while the bus is idle but a line is already low counts as lost arbitration and raises no transfer-stop flag.

Top module: `i2c_xfer_hold`

## Requirements
- R1: A byte-done strobe sets the transfer-stop flag (`flag_o`) in the next cycle when at least one qualifier holds. With no qualifier, the flag keeps reading 0.
- R2: The qualifiers are: master mode, addressed slave, general call received, an arbitration-lost strobe since the previous byte-done (or in the same cycle), and a busy-bus start strobe since the previous byte-done (or in the same cycle).
- R3: `scl_hold_o` is high exactly while the transfer-stop flag is 1. It first rises in the cycle after a byte-done strobe and is low during the byte.
- R4: A write with data bit 0 at 0 clears the transfer-stop flag and releases SCL in the next cycle.
- R5: A write with data bit 0 at 1 leaves the transfer-stop flag unchanged. Data bit 1 at 1 likewise leaves the arbitration-lost flag unchanged.
- R6: A start-seen or stop-seen strobe clears the transfer-stop flag when master mode is active. In slave mode these strobes leave the flag alone.
- R7: A write that raises data bit 3 from 0 sets the arbitration-lost flag when bus busy is 0 and SDA or SCL reads 0, and it leaves the master-start bit at 0. The transfer-stop flag stays 0. When both lines are high, the master-start bit becomes 1 instead.
- R8: `irq_o` is the transfer-stop flag AND the enable (data bit 2), registered. The flag updates whatever the enable is.
- R9: When a set event and a clear of the transfer-stop flag fall in the same cycle, the flag ends at 1.
- R10: During reset, and whenever `en_i` is 0, both flags, the enable, master-start, `irq_o` and `scl_hold_o` read 0, and event strobes are ignored.
- R11: The arbitration-lost strobe sets `arb_flag_o` in the next cycle. A write with data bit 1 at 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable |
| byte_done_i | input | 1 | Byte including ACK finished (strobe) |
| start_det_i | input | 1 | Start condition seen (strobe) |
| stop_det_i | input | 1 | Stop condition seen (strobe) |
| arb_lost_i | input | 1 | Arbitration lost (strobe) |
| busy_start_i | input | 1 | Another device tried a start on a busy bus (strobe) |
| is_master_i | input | 1 | Device is bus master |
| addr_match_i | input | 1 | Device is an addressed slave |
| gen_call_i | input | 1 | General call address received |
| bus_busy_i | input | 1 | Bus busy status |
| sda_in_i | input | 1 | Sampled SDA level |
| scl_in_i | input | 1 | Sampled SCL level |
| wr_i | input | 1 | Register write strobe |
| wr_data_i | input | WR_W | Write data: bit0 flag, bit1 arb flag, bit2 enable, bit3 master start |
| flag_o | output | 1 | Transfer-stop flag |
| arb_flag_o | output | 1 | Arbitration-lost flag |
| ien_o | output | 1 | Interrupt enable bit |
| mstart_o | output | 1 | Master-start bit |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | SCL pull-low enable |

## Verification
A wrong flag state appears on `flag_o` and `scl_hold_o` one cycle after the event that caused it. It also appears on `irq_o` in the same cycle when the enable is set. So every check samples exactly one clock after the stimulus. A stale qualifier pending bit stays invisible until the next byte-done strobe. The bench therefore checks a byte that has no qualifier, and bytes that use each pending source, to expose a pending bit that was left set or never set. A priority fault between set and clear shows only when both arrive in the same cycle, so that case is driven on purpose.

// File: rtl/i2c_hold_pkg.sv
package i2c_hold_pkg;
  localparam int WR_W   = 4;
  localparam int B_FLAG = 0;
  localparam int B_ARB  = 1;
  localparam int B_IEN  = 2;
  localparam int B_MST  = 3;
  localparam int NQUAL  = 5;
endpackage

// File: rtl/i2c_hold_qual.sv
module i2c_hold_qual #(
  parameter int NQ = i2c_hold_pkg::NQUAL
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic byte_done_i,
  input  logic arb_lost_i,
  input  logic busy_start_i,
  input  logic is_master_i,
  input  logic addr_match_i,
  input  logic gen_call_i,
  output logic qual_o
);
  logic arb_pend_q, busy_pend_q;
  logic [NQ-1:0] src;

  // pending events are remembered until the byte that they belong to ends
  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      arb_pend_q  <= 1'b0;
      busy_pend_q <= 1'b0;
    end else if (byte_done_i) begin
      arb_pend_q  <= 1'b0;
      busy_pend_q <= 1'b0;
    end else begin
      if (arb_lost_i)   arb_pend_q  <= 1'b1;
      if (busy_start_i) busy_pend_q <= 1'b1;
    end
  end

  always_comb begin
    src = '0;
    src[0] = is_master_i;
    src[1] = addr_match_i;
    src[2] = gen_call_i;
    src[3] = arb_pend_q | arb_lost_i;
    src[4] = busy_pend_q | busy_start_i;
  end

  assign qual_o = |src;
endmodule

// File: rtl/i2c_hold_arb.sv
module i2c_hold_arb #(
  parameter int WR_W = i2c_hold_pkg::WR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            arb_lost_i,
  input  logic            bus_busy_i,
  input  logic            sda_in_i,
  input  logic            scl_in_i,
  input  logic            wr_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            arb_flag_o,
  output logic            mstart_o
);
  import i2c_hold_pkg::*;
  logic arb_q, mst_q, guard;

  // start request on an idle bus whose lines are not both high
  assign guard = wr_i && wr_data_i[B_MST] && !mst_q && !bus_busy_i &&
                 (!sda_in_i || !scl_in_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      arb_q <= 1'b0;
      mst_q <= 1'b0;
    end else begin
      if (arb_lost_i || guard)             arb_q <= 1'b1;
      else if (wr_i && !wr_data_i[B_ARB])  arb_q <= 1'b0;
      if (arb_lost_i || guard)             mst_q <= 1'b0;
      else if (wr_i)                       mst_q <= wr_data_i[B_MST];
    end
  end

  assign arb_flag_o = arb_q;
  assign mstart_o   = mst_q;
endmodule

// File: rtl/i2c_hold_flag.sv
module i2c_hold_flag #(
  parameter int WR_W = i2c_hold_pkg::WR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            byte_done_i,
  input  logic            qual_i,
  input  logic            start_det_i,
  input  logic            stop_det_i,
  input  logic            is_master_i,
  input  logic            wr_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            flag_o,
  output logic            ien_o,
  output logic            irq_o
);
  import i2c_hold_pkg::*;
  logic flag_q, flag_d, ien_q, ien_d, irq_q, set_ev, clr_ev;

  assign set_ev = byte_done_i && qual_i;
  assign clr_ev = (wr_i && !wr_data_i[B_FLAG]) ||
                  (is_master_i && (start_det_i || stop_det_i));

  always_comb begin
    flag_d = flag_q;
    ien_d  = ien_q;
    if (wr_i) ien_d = wr_data_i[B_IEN];
    if (set_ev)      flag_d = 1'b1;   // set wins: no event is lost
    else if (clr_ev) flag_d = 1'b0;
    if (!en_i) begin
      flag_d = 1'b0;
      ien_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ien_q  <= ien_d;
      irq_q  <= flag_d & ien_d;
    end
  end

  assign flag_o = flag_q;
  assign ien_o  = ien_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/i2c_xfer_hold.sv
module i2c_xfer_hold #(
  parameter int WR_W = i2c_hold_pkg::WR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            byte_done_i,
  input  logic            start_det_i,
  input  logic            stop_det_i,
  input  logic            arb_lost_i,
  input  logic            busy_start_i,
  input  logic            is_master_i,
  input  logic            addr_match_i,
  input  logic            gen_call_i,
  input  logic            bus_busy_i,
  input  logic            sda_in_i,
  input  logic            scl_in_i,
  input  logic            wr_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            flag_o,
  output logic            arb_flag_o,
  output logic            ien_o,
  output logic            mstart_o,
  output logic            irq_o,
  output logic            scl_hold_o
);
  logic qual;
  logic flag;

  i2c_hold_qual u_qual (
    .clk(clk), .rst(rst), .en_i(en_i), .byte_done_i(byte_done_i),
    .arb_lost_i(arb_lost_i), .busy_start_i(busy_start_i),
    .is_master_i(is_master_i), .addr_match_i(addr_match_i),
    .gen_call_i(gen_call_i), .qual_o(qual)
  );

  i2c_hold_arb #(.WR_W(WR_W)) u_arb (
    .clk(clk), .rst(rst), .en_i(en_i), .arb_lost_i(arb_lost_i),
    .bus_busy_i(bus_busy_i), .sda_in_i(sda_in_i), .scl_in_i(scl_in_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i),
    .arb_flag_o(arb_flag_o), .mstart_o(mstart_o)
  );

  i2c_hold_flag #(.WR_W(WR_W)) u_flag (
    .clk(clk), .rst(rst), .en_i(en_i), .byte_done_i(byte_done_i),
    .qual_i(qual), .start_det_i(start_det_i), .stop_det_i(stop_det_i),
    .is_master_i(is_master_i), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .flag_o(flag), .ien_o(ien_o), .irq_o(irq_o)
  );

  assign flag_o     = flag;
  assign scl_hold_o = flag;   // bus pauses exactly while the flag is up
endmodule

// File: rtl/i2c_xfer_hold_chk.sv
module i2c_xfer_hold_chk #(
  parameter int WR_W = i2c_hold_pkg::WR_W
) (
  input logic            clk,
  input logic            rst,
  input logic            en_i,
  input logic            byte_done_i,
  input logic            start_det_i,
  input logic            stop_det_i,
  input logic            arb_lost_i,
  input logic            busy_start_i,
  input logic            is_master_i,
  input logic            addr_match_i,
  input logic            gen_call_i,
  input logic            bus_busy_i,
  input logic            sda_in_i,
  input logic            scl_in_i,
  input logic            wr_i,
  input logic [WR_W-1:0] wr_data_i,
  input logic            flag_o,
  input logic            arb_flag_o,
  input logic            ien_o,
  input logic            mstart_o,
  input logic            irq_o,
  input logic            scl_hold_o
);
  assert_master_byte_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (en_i && byte_done_i && is_master_i) |=> flag_o);

  assert_hold_after_byte_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_hold_o) |-> $past(byte_done_i));

  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (en_i && wr_i && !wr_data_i[0] && !byte_done_i) |=> (!flag_o && !scl_hold_o));

  assert_w1_no_set_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && wr_i && wr_data_i[0] && !flag_o && !byte_done_i) |=> !flag_o);

  assert_guard_no_int_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && wr_i && wr_data_i[3] && !mstart_o && !bus_busy_i &&
     (!sda_in_i || !scl_in_i) && !byte_done_i && !flag_o) |=> (arb_flag_o && !flag_o));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_o && ien_o));

  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!flag_o && !arb_flag_o && !irq_o && !scl_hold_o && !mstart_o));

  assert_arb_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (en_i && arb_lost_i) |=> arb_flag_o);
endmodule

bind i2c_xfer_hold i2c_xfer_hold_chk #(.WR_W(WR_W)) u_chk (.*);

// File: tb/i2c_xfer_hold_tb.sv
module i2c_xfer_hold_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, byte_done_i = 1'b0, start_det_i = 1'b0, stop_det_i = 1'b0;
  logic arb_lost_i = 1'b0, busy_start_i = 1'b0, is_master_i = 1'b0;
  logic addr_match_i = 1'b0, gen_call_i = 1'b0, bus_busy_i = 1'b0;
  logic sda_in_i = 1'b1, scl_in_i = 1'b1, wr_i = 1'b0;
  logic [3:0] wr_data_i = '0;
  logic flag_o, arb_flag_o, ien_o, mstart_o, irq_o, scl_hold_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_xfer_hold u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write(input logic [3:0] d);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic byte_end();
    byte_done_i = 1'b1;
    @(negedge clk);
    byte_done_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; en_i = 1'b1;
    @(negedge clk);
    chk("R10 reset flag", flag_o, 1'b0);
    chk("R10 reset hold", scl_hold_o, 1'b0);
    chk("R10 reset irq", irq_o, 1'b0);
    chk("R10 reset arb", arb_flag_o, 1'b0);
  endtask

  task automatic t_no_qual();
    repeat (2) @(negedge clk);
    chk("R3 hold low during byte", scl_hold_o, 1'b0);
    byte_end();
    chk("R1 no qualifier", flag_o, 1'b0);
  endtask

  task automatic t_master_byte();
    is_master_i = 1'b1;
    byte_end();
    chk("R1 master sets flag", flag_o, 1'b1);
    chk("R3 hold follows", scl_hold_o, 1'b1);
    chk("R8 no irq while disabled", irq_o, 1'b0);
    write(4'b0001);
    chk("R5 write 1 keeps flag", flag_o, 1'b1);
    write(4'b0000);
    chk("R4 write 0 clears", flag_o, 1'b0);
    chk("R4 hold released", scl_hold_o, 1'b0);
    is_master_i = 1'b0;
  endtask

  task automatic t_qualifiers();
    addr_match_i = 1'b1; byte_end(); addr_match_i = 1'b0;
    chk("R2 addressed slave", flag_o, 1'b1);
    write(4'b0000);
    gen_call_i = 1'b1; byte_end(); gen_call_i = 1'b0;
    chk("R2 general call", flag_o, 1'b1);
    write(4'b0000);
    arb_lost_i = 1'b1; @(negedge clk); arb_lost_i = 1'b0;
    chk("R11 arb strobe sets", arb_flag_o, 1'b1);
    byte_end();
    chk("R2 arb lost pending", flag_o, 1'b1);
    write(4'b0010);
    chk("R5 arb write 1 keeps", arb_flag_o, 1'b1);
    write(4'b0000);
    chk("R11 arb write 0 clears", arb_flag_o, 1'b0);
    busy_start_i = 1'b1; @(negedge clk); busy_start_i = 1'b0;
    byte_end();
    chk("R2 busy start pending", flag_o, 1'b1);
    write(4'b0000);
    byte_end();
    chk("R2 pending consumed", flag_o, 1'b0);
  endtask

  task automatic t_start_stop();
    is_master_i = 1'b1; byte_end();
    start_det_i = 1'b1; @(negedge clk); start_det_i = 1'b0;
    chk("R6 master start clears", flag_o, 1'b0);
    byte_end();
    stop_det_i = 1'b1; @(negedge clk); stop_det_i = 1'b0;
    chk("R6 master stop clears", flag_o, 1'b0);
    is_master_i = 1'b0;
    addr_match_i = 1'b1; byte_end(); addr_match_i = 1'b0;
    stop_det_i = 1'b1; @(negedge clk); stop_det_i = 1'b0;
    chk("R6 slave stop keeps", flag_o, 1'b1);
    write(4'b0000);
  endtask

  task automatic t_guard();
    sda_in_i = 1'b0;
    write(4'b1000);
    chk("R7 arb flag set", arb_flag_o, 1'b1);
    chk("R7 no transfer flag", flag_o, 1'b0);
    chk("R7 start bit dropped", mstart_o, 1'b0);
    sda_in_i = 1'b1;
    write(4'b0000);
    write(4'b1000);
    chk("R7 lines high start ok", mstart_o, 1'b1);
    chk("R7 lines high no arb", arb_flag_o, 1'b0);
    write(4'b0000);
  endtask

  task automatic t_irq_and_race();
    write(4'b0100);
    is_master_i = 1'b1; byte_end();
    chk("R8 irq raised", irq_o, 1'b1);
    write(4'b0100);
    chk("R8 irq drops with flag", irq_o, 1'b0);
    wr_i = 1'b1; wr_data_i = 4'b0100; byte_done_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; byte_done_i = 1'b0;
    chk("R9 set beats clear", flag_o, 1'b1);
    en_i = 1'b0; @(negedge clk);
    chk("R10 disable clears flag", flag_o, 1'b0);
    chk("R10 disable clears irq", irq_o, 1'b0);
    chk("R10 disable clears enable", ien_o, 1'b0);
    byte_end();
    chk("R10 event ignored", flag_o, 1'b0);
    en_i = 1'b1; is_master_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_no_qual();
    t_master_byte();
    t_qualifiers();
    t_start_stop();
    t_guard();
    t_irq_and_race();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule